// File: doc/BRIEF.md
# Bidirectional Product-Term Sharing Chain

This block joins the OR stages of the macrocells in one logic group. Every macrocell owns five product terms. A per-macrocell configuration word chooses which of those terms stay in the local sum. The rest are exported as a partial sum to the neighbour with the next higher index or the next lower index. A macrocell may also absorb the partial sum that arrives from either neighbour into its own sum.

An exporting macrocell that does not absorb an arriving partial sum merges it into its own export. Chains of hops can therefore carry terms across the whole group, so one macrocell can collect every term in it. For each macrocell the block also reports the logic span: the largest number of hops that any absorbed partial sum has made. It flags any macrocell that sends out and absorbs on the same link. The block is purely combinational. The term generation, the storage element and the signal routing sit outside it.

Top module: `ptalloc_chain`

## Requirements
- R1: Term j of macrocell i is `pt_in[5*i+j]`. The configuration of macrocell i is `cfg_in[9*i+8:9*i]`, laid out as follows: bits 4:0 are the export mask, bit 5 enables export, bit 6 selects the export direction (1 = toward index i+1, 0 = toward index i-1), bit 7 absorbs the sum from index i-1, and bit 8 absorbs the sum from index i+1. With an all-zero configuration word, `sum_out[i]` is the OR of the macrocell's own five terms and its span is 0.
- R2: A term whose mask bit is set contributes nothing to its owner's sum. A term whose mask bit is clear always reaches its owner's sum, whatever borrowing is configured.
- R3: Masked terms of an exporting macrocell appear in the sum of the neighbour in the selected direction, provided that neighbour absorbs from that side. No sum is ever 1 while all terms are 0.
- R4: A macrocell that absorbs a sum sent directly by its neighbour reports span 1. The span is always 0 unless at least one absorb bit is set.
- R5: An exporting macrocell that does not absorb the sum arriving from the opposite side merges that sum into its export, adding one hop. A sum that is absorbed is not forwarded.
- R6: A macrocell that absorbs from both sides reports the larger of the two hop counts.
- R7: An arriving sum that is neither absorbed nor forwarded is dropped. Its terms reach no sum, and a macrocell that absorbs from an inactive link sees span 0.
- R8: Nothing arrives at index 0 from below or at the last index from above. Exports off either end are lost. As a consequence, a macrocell that does not absorb from above has span at most i.
- R9: `err_out[i]` is 1 exactly when macrocell i exports upward while absorbing from above, or exports downward while absorbing from below.
- R10: With N-1 chained exporters feeding one end macrocell, every term in the group reaches it, and its span is N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pt_in | input | N*5 | Product terms, five per macrocell |
| cfg_in | input | N*9 | Per-macrocell configuration words |
| sum_out | output | N | Sum-of-products result per macrocell |
| span_out | output | N*SPAN_W | Logic span per macrocell |
| err_out | output | N | Same-link export/absorb conflict per macrocell |

## Verification
Local summing of unexported terms and absorbing of a neighbour's partial sum can land in the same macrocell output at once. The bench provokes this by setting terms on both the exporter and the absorber. It judges the result by the OR of both contributions and by a span that counts only the borrowed path. Absorbing and forwarding also compete for one arriving sum. This is provoked with a macrocell that both absorbs from below and exports upward, and judged by the terms and span seen one hop further on.

// File: rtl/ptalloc_pkg.sv
package ptalloc_pkg;
    localparam int TERMS = 5;

    typedef struct packed {
        logic             acc_hi;
        logic             acc_lo;
        logic             exp_up;
        logic             exp_en;
        logic [TERMS-1:0] exp_mask;
    } alloc_cfg_t;

    localparam int CFG_W = $bits(alloc_cfg_t);
endpackage

// File: rtl/ptalloc_span.sv
module ptalloc_span #(
    parameter int DW = 5
) (
    input  logic          lo_take,
    input  logic [DW-1:0] lo_dep,
    input  logic          hi_take,
    input  logic [DW-1:0] hi_dep,
    output logic [DW-1:0] span
);
    logic [DW-1:0] lo_v, hi_v;

    always_comb begin
        lo_v = lo_take ? lo_dep : '0;
        hi_v = hi_take ? hi_dep : '0;
        span = (lo_v > hi_v) ? lo_v : hi_v;
    end
endmodule

// File: rtl/ptalloc_cell.sv
module ptalloc_cell
    import ptalloc_pkg::*;
#(
    parameter int DW = 5
) (
    input  logic [TERMS-1:0] pt,
    input  alloc_cfg_t       cfg,
    input  logic             lo_in,
    input  logic             lo_act,
    input  logic [DW-1:0]    lo_dep,
    input  logic             hi_in,
    input  logic             hi_act,
    input  logic [DW-1:0]    hi_dep,
    output logic             up_out,
    output logic             up_act,
    output logic [DW-1:0]    up_dep,
    output logic             dn_out,
    output logic             dn_act,
    output logic [DW-1:0]    dn_dep,
    output logic             sum,
    output logic             err,
    output logic [DW-1:0]    span
);
    logic own_keep, own_send, fwd_lo, fwd_hi;

    always_comb begin
        own_keep = |(pt & ~cfg.exp_mask);
        own_send = |(pt & cfg.exp_mask);
        up_act   = cfg.exp_en & cfg.exp_up;
        dn_act   = cfg.exp_en & ~cfg.exp_up;
        fwd_lo   = up_act & lo_act & ~cfg.acc_lo;
        fwd_hi   = dn_act & hi_act & ~cfg.acc_hi;
        up_out   = up_act & (own_send | (fwd_lo & lo_in));
        dn_out   = dn_act & (own_send | (fwd_hi & hi_in));
        up_dep   = !up_act ? '0 : (fwd_lo ? lo_dep + DW'(1) : DW'(1));
        dn_dep   = !dn_act ? '0 : (fwd_hi ? hi_dep + DW'(1) : DW'(1));
        sum      = own_keep | (cfg.acc_lo & lo_act & lo_in)
                            | (cfg.acc_hi & hi_act & hi_in);
        err      = (up_act & cfg.acc_hi) | (dn_act & cfg.acc_lo);
    end

    ptalloc_span #(.DW(DW)) u_span (
        .lo_take (cfg.acc_lo & lo_act),
        .lo_dep  (lo_dep),
        .hi_take (cfg.acc_hi & hi_act),
        .hi_dep  (hi_dep),
        .span    (span)
    );
endmodule

// File: rtl/ptalloc_chain.sv
module ptalloc_chain
    import ptalloc_pkg::*;
#(
    parameter int N      = 18,
    parameter int SPAN_W = $clog2(N + 1)
) (
    input  logic [N*TERMS-1:0]  pt_in,
    input  logic [N*CFG_W-1:0]  cfg_in,
    output logic [N-1:0]        sum_out,
    output logic [N*SPAN_W-1:0] span_out,
    output logic [N-1:0]        err_out
);
    logic              up_d [N];
    logic              up_a [N];
    logic [SPAN_W-1:0] up_p [N];
    logic              dn_d [N];
    logic              dn_a [N];
    logic [SPAN_W-1:0] dn_p [N];
    logic              lo_d [N];
    logic              lo_a [N];
    logic [SPAN_W-1:0] lo_p [N];
    logic              hi_d [N];
    logic              hi_a [N];
    logic [SPAN_W-1:0] hi_p [N];

    for (genvar i = 0; i < N; i++) begin : g_mc
        if (i == 0) begin : g_bot
            assign lo_d[i] = 1'b0;
            assign lo_a[i] = 1'b0;
            assign lo_p[i] = '0;
        end else begin : g_lo
            assign lo_d[i] = up_d[i-1];
            assign lo_a[i] = up_a[i-1];
            assign lo_p[i] = up_p[i-1];
        end
        if (i == N - 1) begin : g_top
            assign hi_d[i] = 1'b0;
            assign hi_a[i] = 1'b0;
            assign hi_p[i] = '0;
        end else begin : g_hi
            assign hi_d[i] = dn_d[i+1];
            assign hi_a[i] = dn_a[i+1];
            assign hi_p[i] = dn_p[i+1];
        end

        ptalloc_cell #(.DW(SPAN_W)) u_cell (
            .pt     (pt_in[i*TERMS +: TERMS]),
            .cfg    (alloc_cfg_t'(cfg_in[i*CFG_W +: CFG_W])),
            .lo_in  (lo_d[i]),
            .lo_act (lo_a[i]),
            .lo_dep (lo_p[i]),
            .hi_in  (hi_d[i]),
            .hi_act (hi_a[i]),
            .hi_dep (hi_p[i]),
            .up_out (up_d[i]),
            .up_act (up_a[i]),
            .up_dep (up_p[i]),
            .dn_out (dn_d[i]),
            .dn_act (dn_a[i]),
            .dn_dep (dn_p[i]),
            .sum    (sum_out[i]),
            .err    (err_out[i]),
            .span   (span_out[i*SPAN_W +: SPAN_W])
        );
    end
endmodule

// File: rtl/ptalloc_chain_chk.sv
module ptalloc_chain_chk
    import ptalloc_pkg::*;
#(
    parameter int N      = 18,
    parameter int SPAN_W = $clog2(N + 1)
) (
    input logic [N*TERMS-1:0]  pt_in,
    input logic [N*CFG_W-1:0]  cfg_in,
    input logic [N-1:0]        sum_out,
    input logic [N*SPAN_W-1:0] span_out,
    input logic [N-1:0]        err_out
);
    always_comb begin
        if (pt_in == '0)
            assert_no_phantom_sum_R3: assert (sum_out == '0);
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        alloc_cfg_t        c;
        logic [TERMS-1:0]  p;
        logic [SPAN_W-1:0] s;
        assign c = alloc_cfg_t'(cfg_in[i*CFG_W +: CFG_W]);
        assign p = pt_in[i*TERMS +: TERMS];
        assign s = span_out[i*SPAN_W +: SPAN_W];

        always_comb begin
            if (!c.acc_lo && !c.acc_hi && c.exp_mask == '0)
                assert_plain_or_R1: assert (sum_out[i] == |p);
            if (|(p & ~c.exp_mask))
                assert_own_term_kept_R2: assert (sum_out[i]);
            if (s != '0)
                assert_span_needs_absorb_R4: assert (c.acc_lo || c.acc_hi);
            if (!c.acc_hi)
                assert_span_bound_lo_R8: assert (int'(s) <= i);
            if (!c.acc_lo)
                assert_span_bound_hi_R8: assert (int'(s) <= N - 1 - i);
            if (err_out[i])
                assert_err_needs_export_R9: assert (c.exp_en && (c.acc_lo || c.acc_hi));
        end
    end
endmodule

bind ptalloc_chain ptalloc_chain_chk #(.N(N), .SPAN_W(SPAN_W)) u_chk (
    .pt_in    (pt_in),
    .cfg_in   (cfg_in),
    .sum_out  (sum_out),
    .span_out (span_out),
    .err_out  (err_out)
);

// File: tb/tb_ptalloc_chain.sv
module tb_ptalloc_chain;
    localparam int N  = 18;
    localparam int SW = $clog2(N + 1);
    localparam int T  = 5;
    localparam int CW = 9;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [N*T-1:0]     pt_in;
    logic [N*CW-1:0]    cfg_in;
    logic [N-1:0]       sum_out;
    logic [N*SW-1:0]    span_out;
    logic [N-1:0]       err_out;
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ptalloc_chain #(.N(N)) dut (
        .pt_in(pt_in), .cfg_in(cfg_in), .sum_out(sum_out),
        .span_out(span_out), .err_out(err_out)
    );

    // row: {k[4:0], pt[4:0], mask[4:0], local_sum, neighbour_sum}
    localparam logic [16:0] TBL [8] = '{
        {5'd0,  5'b00001, 5'b00001, 1'b0, 1'b1},
        {5'd3,  5'b10000, 5'b00001, 1'b1, 1'b0},
        {5'd7,  5'b00110, 5'b00010, 1'b1, 1'b1},
        {5'd10, 5'b00000, 5'b11111, 1'b0, 1'b0},
        {5'd12, 5'b11111, 5'b11111, 1'b0, 1'b1},
        {5'd16, 5'b01000, 5'b10111, 1'b1, 1'b0},
        {5'd5,  5'b10100, 5'b00100, 1'b1, 1'b1},
        {5'd1,  5'b00000, 5'b00000, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr();
        pt_in  = '0;
        cfg_in = '0;
    endtask

    // cfg bits: [4:0] mask, 5 export, 6 up, 7 absorb-below, 8 absorb-above
    task automatic setc(input int i, input logic [4:0] m, input bit en,
                        input bit up, input bit lo, input bit hi);
        cfg_in[i*CW +: CW] = {hi, lo, up, en, m};
    endtask

    task automatic setp(input int i, input logic [4:0] v);
        pt_in[i*T +: T] = v;
    endtask

    function automatic int spn(input int i);
        return int'(span_out[i*SW +: SW]);
    endfunction

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        clr();
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R1 idle state
        settle();
        chk(sum_out == '0 && span_out == '0 && err_out == '0, "R1 idle", int'(sum_out), 0);

        // table: k exports masked terms up, k+1 absorbs from below (R2 R3 R4)
        for (int r = 0; r < 8; r++) begin
            int k;
            clr();
            k = int'(TBL[r][16:12]);
            setp(k, TBL[r][11:7]);
            setc(k, TBL[r][6:2], 1'b1, 1'b1, 1'b0, 1'b0);
            setc(k + 1, 5'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            settle();
            chk(sum_out[k] == TBL[r][1], "R2 local", int'(sum_out[k]), int'(TBL[r][1]));
            chk(sum_out[k+1] == TBL[r][0], "R3 neighbour", int'(sum_out[k+1]), int'(TBL[r][0]));
            chk(spn(k + 1) == 1 && spn(k) == 0, "R4 one hop", spn(k + 1), 1);
        end

        // R1 plain OR per macrocell
        clr();
        for (int i = 0; i < N; i++) setp(i, 5'((i * 7) % 32));
        settle();
        for (int i = 0; i < N; i++)
            chk(sum_out[i] == (((i * 7) % 32) != 0) && spn(i) == 0, "R1 plain",
                int'(sum_out[i]), int'(((i * 7) % 32) != 0));

        // R3 downward export plus own term in absorber (R2)
        clr();
        setp(6, 5'b01000);
        setc(6, 5'b11000, 1'b1, 1'b0, 1'b0, 1'b0);
        setc(5, 5'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        settle();
        chk(sum_out[5] == 1'b1 && sum_out[6] == 1'b0, "R3 down", int'(sum_out[6:5]), 1);
        chk(spn(5) == 1, "R4 down span", spn(5), 1);
        setp(5, 5'b00001);
        setp(6, 5'b0);
        settle();
        chk(sum_out[5] == 1'b1 && spn(5) == 1, "R2 own kept with borrow", int'(sum_out[5]), 1);

        // R5 absorbed sum not forwarded
        clr();
        setp(2, 5'b00001);
        setc(2, 5'b11111, 1'b1, 1'b1, 1'b0, 1'b0);
        setc(3, 5'b11111, 1'b1, 1'b1, 1'b1, 1'b0);
        setc(4, 5'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        settle();
        chk(sum_out[3] == 1'b1 && sum_out[4] == 1'b0, "R5 absorb stops", int'(sum_out[4:3]), 1);
        chk(spn(4) == 1, "R5 absorb depth", spn(4), 1);

        // R10/R5 full upward chain into top macrocell
        clr();
        for (int i = 0; i < N - 1; i++) setc(i, 5'b11111, 1'b1, 1'b1, 1'b0, 1'b0);
        setc(N - 1, 5'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        setp(0, 5'b00100);
        settle();
        chk(sum_out == (N'(1) << (N - 1)), "R10 far term", int'(sum_out), 1 << (N - 1));
        chk(spn(N - 1) == N - 1, "R10 span", spn(N - 1), N - 1);
        for (int i = 0; i < N - 1; i++) begin
            setp(0, 5'b0);
            setp(i, 5'b10000);
            settle();
            chk(sum_out[N-1] == 1'b1, "R10 every source", int'(sum_out[N-1]), 1);
            setp(i, 5'b0);
        end

        // R6 both sides, max of depths
        clr();
        for (int i = 1; i <= 3; i++) setc(i, 5'b11111, 1'b1, 1'b1, 1'b0, 1'b0);
        setc(5, 5'b11111, 1'b1, 1'b0, 1'b0, 1'b0);
        setc(4, 5'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        setp(5, 5'b00010);
        settle();
        chk(spn(4) == 3 && sum_out[4] == 1'b1, "R6 max span", spn(4), 3);

        // R7 dropped sum
        clr();
        setp(2, 5'b00001);
        setc(2, 5'b00001, 1'b1, 1'b1, 1'b0, 1'b0);
        setc(4, 5'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        settle();
        chk(sum_out == '0, "R7 dropped", int'(sum_out), 0);
        chk(spn(4) == 0, "R7 inactive span", spn(4), 0);

        // R8 ends
        clr();
        setp(0, 5'b11111);
        setp(N - 1, 5'b11111);
        setc(0, 5'b11111, 1'b1, 1'b0, 1'b0, 1'b0);
        setc(N - 1, 5'b11111, 1'b1, 1'b1, 1'b0, 1'b0);
        setc(1, 5'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        setc(N - 2, 5'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        settle();
        chk(sum_out == '0, "R8 ends lost", int'(sum_out), 0);
        chk(spn(1) == 0 && spn(N - 2) == 0, "R8 end spans", spn(1) + spn(N - 2), 0);

        // R9 conflicts
        clr();
        setc(3, 5'b00001, 1'b1, 1'b1, 1'b0, 1'b1);
        setc(8, 5'b00001, 1'b1, 1'b0, 1'b1, 1'b0);
        setc(10, 5'b00001, 1'b1, 1'b1, 1'b1, 1'b0);
        settle();
        chk(err_out == ((N'(1) << 3) | (N'(1) << 8)), "R9 conflict", int'(err_out),
            int'((N'(1) << 3) | (N'(1) << 8)));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule